// File: doc/BRIEF.md
# Prescaled Time Stamp Counter

This block keeps a free-running 16-bit time base. Conversion results are stamped with it. The counter advances by one on each enable pulse from a programmable prescaler, which runs on the system clock. A 4-bit prescaler code picks the divide ratio. Thirteen ratios are available: 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256 and 512. The code can also stop counting altogether.

Software reaches the block through three write paths. The first is a 16-bit control word that holds the prescaler code. The other two are configuration-command ports, and both load the same counter storage. A guard protects the prescaler code. While the code is non-zero, it can only be written back to zero, so a running time base cannot be switched straight to a different rate.

Top module: `stamp_timebase`

## Requirements
- R1: After reset the counter reads 0x0000, the control word reads 0x0000 and the enable output is low.
- R2: While the prescaler code is 0, the counter holds its value unless a port writes it.
- R3: Code values 1 to 13 select divide factors N of 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256 and 512, in rising code order. The enable output `stamp_tick` is high for exactly one clock in every N, and the counter adds one on each such clock.
- R4: Code values 14 and 15 stop counting in the same way as code 0.
- R5: While the stored code is non-zero, a control-word write whose bits [3:0] are non-zero is ignored. A write whose bits [3:0] are zero is accepted.
- R6: While the stored code is 0, any value of bits [3:0] is accepted, including 14 and 15.
- R7: The code sits in bits [3:0] of the control word. Bits [15:4] always read zero, and values written to them are dropped.
- R8: A write on either counter port is visible on `cnt_rdata` from the clock after the write. The read shows the registered count.
- R9: If both counter ports write in the same clock, port A's value is stored. A port write overrides an increment that falls in the same clock.
- R10: The counter wraps from 0xFFFF to 0x0000 on an increment.
- R11: Every accepted control-word write restarts the divider. With the new factor N, the first increment lands on the Nth clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 16 | Control-word write value, code in [3:0] |
| ctl_rdata | output | 16 | Control-word read value |
| cnt_wr_a | input | 1 | Counter write strobe, port A (priority) |
| cnt_wdata_a | input | 16 | Counter write value, port A |
| cnt_wr_b | input | 1 | Counter write strobe, port B |
| cnt_wdata_b | input | 16 | Counter write value, port B |
| cnt_rdata | output | 16 | Current counter value |
| stamp_tick | output | 1 | One-clock prescaler enable pulse |

## Verification
The bench targets these corner cases, each with the failure it would expose:

- **Divider restart.** It counts the exact edge at which the first increment arrives after a code write. A divider that was not restarted, or that was off by one, would move the count one edge early or late.
- **Guard.** It tries switching between two non-zero codes. A weak guard would accept the new rate.
- **Reserved codes.** It writes codes 14 and 15 from zero. A naive decode would let those run at some stray rate instead of freezing the counter.
- **Write priority.** It collides both ports with each other and with a divide-by-one increment, then rolls the counter through 0xFFFF. A wrong priority would store port B's value or an incremented value, and a bad rollover would leave 0xFFFF standing or jump to the wrong value.

// File: rtl/stamp_pkg.sv
`timescale 1ns/1ps
package stamp_pkg;
    localparam int CODE_W = 4;
    localparam int FACT_W = 10;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [FACT_W-1:0] fact_t;

    // Prescaler code to divide factor; 0 means no counting.
    function automatic fact_t code_to_factor(code_t c);
        int   ci;
        fact_t f;
        ci = int'(c);
        f  = '0;
        if (ci >= 1 && ci <= 3)
            f = fact_t'(1 << (ci - 1));
        else if (ci >= 4 && ci <= 7)
            f = fact_t'(2 * (ci - 1));
        else if (ci >= 8 && ci <= 13)
            f = fact_t'(16 << (ci - 8));
        return f;
    endfunction
endpackage

// File: rtl/stamp_guard.sv
`timescale 1ns/1ps
module stamp_guard
    import stamp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output code_t             code,
    output logic              reload
);
    typedef struct packed {
        code_t code;
    } guard_st_t;

    guard_st_t s_d, s_q;
    code_t     new_code;
    logic      accept_d;
    logic      unused_hi;

    assign new_code  = wdata[CODE_W-1:0];
    assign unused_hi = ^wdata[WORD_W-1:CODE_W];

    always_comb begin
        s_d      = s_q;
        accept_d = wr && ((s_q.code == '0) || (new_code == '0));
        if (accept_d)
            s_d.code = new_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign code   = s_q.code;
    assign reload = accept_d;

    // R5
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.code != '0 && wr && wdata[CODE_W-1:0] != '0) |=> $stable(s_q.code));

    // R6
    guard_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.code == '0 && wr) |=> (s_q.code == $past(wdata[CODE_W-1:0])));
endmodule

// File: rtl/stamp_presc.sv
`timescale 1ns/1ps
module stamp_presc
    import stamp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t code,
    input  logic  reload,
    output logic  tick
);
    typedef struct packed {
        fact_t div;
    } presc_st_t;

    presc_st_t s_d, s_q;
    fact_t     factor;
    logic      active;
    logic      hit;

    always_comb begin
        factor = code_to_factor(code);
        active = (factor != '0);
        hit    = active && (s_q.div == factor - fact_t'(1));
        s_d    = s_q;
        if (reload || !active || hit)
            s_d.div = '0;
        else
            s_d.div = s_q.div + fact_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign tick = hit;

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload && factor > fact_t'(1)) |=> !tick);

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && factor != fact_t'(1)) |=> !tick || (factor == fact_t'(1)));
endmodule

// File: rtl/stamp_count.sv
`timescale 1ns/1ps
module stamp_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_a,
    input  logic [CNT_W-1:0] wd_a,
    input  logic             wr_b,
    input  logic [CNT_W-1:0] wd_b,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_a)
            s_d.cnt = wd_a;
        else if (wr_b)
            s_d.cnt = wd_b;
        else if (inc)
            s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // R9
    port_a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> (s_q.cnt == $past(wd_a)));

    // R8
    port_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && !wr_a) |=> (s_q.cnt == $past(wd_b)));

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '1 && inc && !wr_a && !wr_b) |=> (s_q.cnt == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_a && !wr_b) |=> $stable(s_q.cnt));
endmodule

// File: rtl/stamp_timebase.sv
`timescale 1ns/1ps
module stamp_timebase
    import stamp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [WORD_W-1:0] ctl_wdata,
    output logic [WORD_W-1:0] ctl_rdata,
    input  logic              cnt_wr_a,
    input  logic [CNT_W-1:0]  cnt_wdata_a,
    input  logic              cnt_wr_b,
    input  logic [CNT_W-1:0]  cnt_wdata_b,
    output logic [CNT_W-1:0]  cnt_rdata,
    output logic              stamp_tick
);
    code_t code;
    logic  reload;
    logic  tick;

    stamp_guard #(.WORD_W(WORD_W)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .code   (code),
        .reload (reload)
    );

    stamp_presc u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (code),
        .reload (reload),
        .tick   (tick)
    );

    stamp_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .wr_a  (cnt_wr_a),
        .wd_a  (cnt_wdata_a),
        .wr_b  (cnt_wr_b),
        .wd_b  (cnt_wdata_b),
        .cnt   (cnt_rdata)
    );

    assign ctl_rdata  = WORD_W'(code);
    assign stamp_tick = tick;

    // R4
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= code_t'(14) && !cnt_wr_a && !cnt_wr_b) |=> $stable(cnt_rdata));

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |-> !stamp_tick);
endmodule

// File: tb/sim_stamp_timebase.sv
`timescale 1ns/1ps
module sim_stamp_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        cnt_wr_a = 1'b0;
    logic [15:0] cnt_wdata_a = '0;
    logic        cnt_wr_b = 1'b0;
    logic [15:0] cnt_wdata_b = '0;
    logic [15:0] cnt_rdata;
    logic        stamp_tick;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_en = 0;

    int          m_code = 0;
    int          m_ph = 0;
    logic [15:0] m_cnt = '0;

    always #2.5 clk = ~clk;

    stamp_timebase u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .cnt_wr_a(cnt_wr_a), .cnt_wdata_a(cnt_wdata_a),
        .cnt_wr_b(cnt_wr_b), .cnt_wdata_b(cnt_wdata_b),
        .cnt_rdata(cnt_rdata), .stamp_tick(stamp_tick)
    );

    function automatic int exp_factor(int c);
        case (c)
            1: return 1;    2: return 2;    3: return 4;    4: return 6;
            5: return 8;    6: return 10;   7: return 12;   8: return 16;
            9: return 32;   10: return 64;  11: return 128; 12: return 256;
            13: return 512;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_tick(int c, int ph);
        int f;
        f = exp_factor(c);
        return (f != 0) && (ph == f - 1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model, advanced at each rising edge from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_ph = 0; m_cnt = '0;
        end else begin
            bit t;
            bit acc;
            t   = exp_tick(m_code, m_ph);
            acc = ctl_wr && (m_code == 0 || ctl_wdata[3:0] == 4'd0);
            if (cnt_wr_a)      m_cnt = cnt_wdata_a;
            else if (cnt_wr_b) m_cnt = cnt_wdata_b;
            else if (t)        m_cnt = m_cnt + 16'd1;
            if (acc) begin
                m_code = int'(ctl_wdata[3:0]);
                m_ph = 0;
            end else if (exp_factor(m_code) == 0 || t) begin
                m_ph = 0;
            end else begin
                m_ph++;
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge (R3, R7, R8).
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R8 model count", {16'd0, cnt_rdata}, {16'd0, m_cnt});
            chk("R3 model tick", {31'd0, stamp_tick}, {31'd0, exp_tick(m_code, m_ph)});
            chk("R7 model ctl", {16'd0, ctl_rdata}, 32'(m_code));
        end
    end

    task automatic wr_ctl(logic [15:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_cnt(bit a, logic [15:0] va, bit b, logic [15:0] vb);
        @(negedge clk);
        cnt_wr_a = a; cnt_wdata_a = va; cnt_wr_b = b; cnt_wdata_b = vb;
        @(negedge clk);
        cnt_wr_a = 1'b0; cnt_wr_b = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h1d2c3b4a));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;

        // R1 reset state
        chk("R1 count", {16'd0, cnt_rdata}, 32'h0);
        chk("R1 ctl", {16'd0, ctl_rdata}, 32'h0);
        chk("R1 tick", {31'd0, stamp_tick}, 32'h0);

        // R2 disabled code keeps the count
        repeat (20) @(negedge clk);
        chk("R2 idle count", {16'd0, cnt_rdata}, 32'h0);

        // R11 restart and R3 divide by 4
        wr_ctl(16'h0003);
        repeat (3) @(negedge clk);
        chk("R11 before first", {16'd0, cnt_rdata}, 32'h0);
        @(negedge clk);
        chk("R11 first increment", {16'd0, cnt_rdata}, 32'h1);
        repeat (8) @(negedge clk);
        chk("R3 divide by 4", {16'd0, cnt_rdata}, 32'h3);

        // R5 guard
        wr_ctl(16'h0005);
        chk("R5 rejected change", {16'd0, ctl_rdata}, 32'h3);
        wr_ctl(16'h0000);
        chk("R5 accepted zero", {16'd0, ctl_rdata}, 32'h0);
        held = cnt_rdata;
        repeat (10) @(negedge clk);
        chk("R2 held after disable", {16'd0, cnt_rdata}, {16'd0, held});

        // R7 and R6
        wr_ctl(16'hABC6);
        chk("R7 upper bits dropped", {16'd0, ctl_rdata}, 32'h6);
        wr_ctl(16'h0000);
        wr_ctl(16'h000E);
        chk("R6 reserved 14 accepted", {16'd0, ctl_rdata}, 32'hE);
        held = cnt_rdata;
        repeat (30) @(negedge clk);
        chk("R4 code 14 frozen", {16'd0, cnt_rdata}, {16'd0, held});
        wr_ctl(16'h0000);
        wr_ctl(16'h000F);
        chk("R6 reserved 15 accepted", {16'd0, ctl_rdata}, 32'hF);
        repeat (10) @(negedge clk);
        chk("R4 code 15 frozen", {16'd0, cnt_rdata}, {16'd0, held});
        wr_ctl(16'h0000);

        // R8 both ports
        wr_cnt(0, 16'h0, 1, 16'h1234);
        chk("R8 port B", {16'd0, cnt_rdata}, 32'h1234);
        wr_cnt(1, 16'h5678, 0, 16'h0);
        chk("R8 port A", {16'd0, cnt_rdata}, 32'h5678);

        // R9 priority with divide by 1
        wr_ctl(16'h0001);
        wr_cnt(1, 16'h1111, 1, 16'h2222);
        chk("R9 port A wins", {16'd0, cnt_rdata}, 32'h1111);
        @(negedge clk);
        chk("R3 divide by 1", {16'd0, cnt_rdata}, 32'h1112);
        wr_cnt(0, 16'h0, 1, 16'h4444);
        chk("R9 write beats increment", {16'd0, cnt_rdata}, 32'h4444);

        // R10 wrap
        wr_cnt(1, 16'hFFFE, 0, 16'h0);
        @(negedge clk);
        chk("R10 reach max", {16'd0, cnt_rdata}, 32'hFFFF);
        @(negedge clk);
        chk("R10 wrap", {16'd0, cnt_rdata}, 32'h0);
        wr_ctl(16'h0000);

        // Random traffic against the model (R3, R5, R6, R9, R11)
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            ctl_wr = ($urandom % 10) == 0;
            ctl_wdata = 16'($urandom);
            if ($urandom % 2 == 0) ctl_wdata[3:0] = 4'd0;
            cnt_wr_a = ($urandom % 50) == 0;
            cnt_wdata_a = 16'($urandom);
            if ($urandom % 3 == 0) cnt_wdata_a[15:4] = 12'hFFF;
            cnt_wr_b = ($urandom % 50) == 0;
            cnt_wdata_b = 16'($urandom);
        end
        @(negedge clk);
        ctl_wr = 1'b0; cnt_wr_a = 1'b0; cnt_wr_b = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule